// File: doc/BRIEF.md
# Stereo Audio Sample Bridge with Bus-Side FIFOs

This block sits between a processor on an AXI4-Lite bus and an audio codec front end. Software streams playback audio by writing packed stereo words to a push register. The block queues them in a playback FIFO and offers them, one stereo pair at a time, on a valid/ready port that carries 24-bit samples. Captured audio arrives on a second valid/ready port, is narrowed to 16 bits, queued in a capture FIFO and handed to software by reading a pop register. A control and status register clears either FIFO on command and reports whether each FIFO is empty or full.

Each stored word packs the right sample in bits 31:16 and the left sample in bits 15:0, both signed 16-bit. Widening appends eight zero bits below the 16-bit sample. Narrowing keeps the top 16 bits of the 24-bit sample. Both FIFOs and the bus logic share one clock.

The bus side is a three-state machine. ST_IDLE waits for a request. The transition IDLE-to-WR_RESP is taken when the write address and the write data are both valid, and the write acts in that cycle. The transition IDLE-to-RD_DATA is taken when a read address is valid and no complete write is pending, and the read data is latched in that cycle. The transitions WR_RESP-to-IDLE and RD_DATA-to-IDLE are taken when the master accepts the response.

Top module: `audio_fifo_bridge`

## Requirements
- R1: After reset both FIFOs are empty, the status register (offset 0x0) reads 0x0000000C, play_valid is 0 and cap_ready is 1.
- R2: A write to offset 0x0 with bit 0 set empties the playback FIFO, and one with bit 1 set empties the capture FIFO. These bits are not stored, so bits 1:0 of a read from 0x0 are always 0.
- R3: A read from offset 0x0 returns capture-empty in bit 2, playback-empty in bit 3, capture-full in bit 4 and playback-full in bit 5, each 1 when true. All other bits read 0.
- R4: A write to offset 0x4 appends wdata to the playback FIFO. play_valid is 1 whenever that FIFO holds an entry, and entries leave in order on each cycle with play_valid and play_ready both 1. The head word appears as play_right = {wdata[31:16], 8'h00} and play_left = {wdata[15:0], 8'h00}.
- R5: cap_ready is 1 whenever the capture FIFO is not full. A pair taken with cap_valid is stored as {cap_right[23:8], cap_left[23:8]}. A read from offset 0x8 returns the oldest stored word and removes it.
- R6: A write to 0x4 while the playback FIFO is full is dropped and still gets bresp OKAY (2'b00). A pair offered while the capture FIFO is full is discarded.
- R7: A read from 0x8 while the capture FIFO is empty returns 0 with rresp OKAY (2'b00) and leaves the FIFO unchanged.
- R8: The word offsets 0xC through 0x3C read as 0, and writes to them change no FIFO and no status bit.
- R9: irq is always 0.
- R10: Only one bus transaction runs at a time, and a complete write wins over a read. bvalid and rvalid each stay high, with rdata stable, until bready or rready, and every response is OKAY.
- R11: A bus push and a codec drain of the playback FIFO in the same cycle both take effect. The same holds for a codec push and a bus pop of the capture FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and both FIFOs |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Interrupt, held at 0 |
| play_valid | output | 1 | A playback pair is available |
| play_ready | input | 1 | Codec side takes the playback pair |
| play_left | output | 24 | Widened left playback sample |
| play_right | output | 24 | Widened right playback sample |
| cap_valid | input | 1 | A capture pair is offered |
| cap_ready | output | 1 | Capture FIFO can take a pair |
| cap_left | input | 24 | Left capture sample |
| cap_right | input | 24 | Right capture sample |

## Verification
Two events can land on the same clock edge: a bus push into the playback FIFO and a codec-side drain from it, and likewise a codec-side capture and a bus pop. The bench provokes the first by raising play_ready on the same falling edge on which it presents a push. The drain monitor must then see the older pair and, one cycle later, the new pair, after which the FIFO reads empty. For the capture path it offers a pair on the same cycle as a pop of a one-entry FIFO. The pop must return the old word, and the next pop must return the new pair narrowed.

// File: rtl/audio_bridge_pkg.sv
package audio_bridge_pkg;

    localparam int unsigned STORE_W = 16;
    localparam int unsigned CODEC_W = 24;
    localparam int unsigned PAD_W   = CODEC_W - STORE_W;

    // Word indices inside the register window
    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_PUSH = 1;
    localparam int unsigned IDX_POP  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_RESP = 2'd1,
        ST_RD_DATA = 2'd2
    } bus_state_t;

    function automatic logic [CODEC_W-1:0] widen(input logic [STORE_W-1:0] s);
        return {s, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [STORE_W-1:0] narrow(input logic [CODEC_W-1:0] s);
        return s[CODEC_W-1 -: STORE_W];
    endfunction

endpackage

// File: rtl/abf_fifo.sv
module abf_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: a push into a full FIFO with no pop leaves it full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R7: a pop from an empty FIFO with no push leaves it empty
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);

    // R2: a clear command empties the FIFO on the next cycle
    p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

    // R11: simultaneous push and pop keep the occupancy flags
    p_push_pop_same_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && !clr) |=> (!empty && $stable(full)));

endmodule

// File: rtl/abf_regs.sv
module abf_regs
    import audio_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              rready,
    input  logic              play_empty,
    input  logic              play_full,
    input  logic              cap_empty,
    input  logic              cap_full,
    input  logic [31:0]       cap_head,
    output logic              play_push,
    output logic [31:0]       play_data,
    output logic              play_clr,
    output logic              cap_pop,
    output logic              cap_clr
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    bus_state_t        state, state_nx;
    logic              wr_go, rd_go;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [31:0]       rd_value;
    logic [3:0]        unused_addr_bits;

    assign wr_idx           = awaddr[ADDR_W-1:2];
    assign rd_idx           = araddr[ADDR_W-1:2];
    assign unused_addr_bits = {awaddr[1:0], araddr[1:0]};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs and next state
    always_comb begin
        state_nx  = state;
        wr_go     = 1'b0;
        rd_go     = 1'b0;
        awready   = 1'b0;
        wready    = 1'b0;
        arready   = 1'b0;
        bvalid    = 1'b0;
        rvalid    = 1'b0;
        play_push = 1'b0;
        play_clr  = 1'b0;
        cap_pop   = 1'b0;
        cap_clr   = 1'b0;
        play_data = wdata;
        rd_value  = '0;
        unique case (state)
            ST_IDLE: begin
                if (awvalid && wvalid) begin
                    wr_go    = 1'b1;
                    awready  = 1'b1;
                    wready   = 1'b1;
                    state_nx = ST_WR_RESP;
                end else if (arvalid) begin
                    rd_go    = 1'b1;
                    arready  = 1'b1;
                    state_nx = ST_RD_DATA;
                end
            end
            ST_WR_RESP: begin
                bvalid = 1'b1;
                if (bready) state_nx = ST_IDLE;
            end
            ST_RD_DATA: begin
                rvalid = 1'b1;
                if (rready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase

        if (wr_go) begin
            if (wr_idx == IDX_W'(IDX_PUSH)) play_push = 1'b1;
            if (wr_idx == IDX_W'(IDX_CTRL)) begin
                play_clr = wdata[0];
                cap_clr  = wdata[1];
            end
        end
        if (rd_go) begin
            if (rd_idx == IDX_W'(IDX_CTRL)) begin
                rd_value = {26'd0, play_full, cap_full, play_empty, cap_empty, 2'b00};
            end else if (rd_idx == IDX_W'(IDX_POP)) begin
                cap_pop  = !cap_empty;
                rd_value = cap_empty ? 32'd0 : cap_head;
            end
        end
    end

    // Read data register, loaded when a read is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_go) begin
            rdata <= rd_value;
        end
    end

    // R10: a write response stays offered until taken
    p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R10: read data stays offered and stable until taken
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R10: never two responses at once
    p_one_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bvalid, rvalid}));

    // R10: no new request is accepted while a response is pending
    p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid || rvalid) |-> !(awready || arready));

endmodule

// File: rtl/audio_fifo_bridge.sv
module audio_fifo_bridge
    import audio_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              irq,
    output logic              play_valid,
    input  logic              play_ready,
    output logic [23:0]       play_left,
    output logic [23:0]       play_right,
    input  logic              cap_valid,
    output logic              cap_ready,
    input  logic [23:0]       cap_left,
    input  logic [23:0]       cap_right
);
    localparam int unsigned WORD_W = 2 * STORE_W;

    logic              play_push, play_clr, play_empty, play_full;
    logic [WORD_W-1:0] play_data, play_head;
    logic              cap_pop, cap_clr, cap_empty, cap_full;
    logic [WORD_W-1:0] cap_head, cap_word;

    assign irq     = 1'b0;
    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    abf_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (s_awaddr),
        .awvalid    (s_awvalid),
        .awready    (s_awready),
        .wdata      (s_wdata),
        .wvalid     (s_wvalid),
        .wready     (s_wready),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .araddr     (s_araddr),
        .arvalid    (s_arvalid),
        .arready    (s_arready),
        .rdata      (s_rdata),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .play_empty (play_empty),
        .play_full  (play_full),
        .cap_empty  (cap_empty),
        .cap_full   (cap_full),
        .cap_head   (cap_head),
        .play_push  (play_push),
        .play_data  (play_data),
        .play_clr   (play_clr),
        .cap_pop    (cap_pop),
        .cap_clr    (cap_clr)
    );

    abf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_play_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (play_clr),
        .push      (play_push),
        .push_data (play_data),
        .pop       (play_valid && play_ready),
        .head      (play_head),
        .empty     (play_empty),
        .full      (play_full)
    );

    assign play_valid = !play_empty;
    assign play_right = widen(play_head[WORD_W-1:STORE_W]);
    assign play_left  = widen(play_head[STORE_W-1:0]);

    assign cap_ready = !cap_full;
    assign cap_word  = {narrow(cap_right), narrow(cap_left)};

    abf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_cap_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cap_clr),
        .push      (cap_valid && cap_ready),
        .push_data (cap_word),
        .pop       (cap_pop),
        .head      (cap_head),
        .empty     (cap_empty),
        .full      (cap_full)
    );

    // R5: an accepted capture pair makes the capture FIFO non-empty
    p_cap_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_ready && !cap_clr) |=> !cap_empty);

    // R4: a successful playback push makes play_valid high next cycle
    p_play_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awready && s_wvalid && (s_awaddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_PUSH)) && !play_full)
        |=> play_valid);

endmodule

// File: tb/audio_fifo_bridge_tb.sv
module audio_fifo_bridge_tb;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned ADDR_W = 6;
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h1234_ABCD, 32'h8000_7FFF, 32'h0000_0000,
        32'hFFFF_0001, 32'h5A5A_A5A5, 32'h0F0F_F0F0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, arvalid = 0;
    logic [31:0] wdata = '0;
    logic bready = 1'b1, rready = 1'b1;
    logic awready, wready, arready, bvalid, rvalid, irq;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic play_valid, play_ready = 1'b0;
    logic [23:0] play_left, play_right;
    logic cap_valid = 1'b0, cap_ready;
    logic [23:0] cap_left = '0, cap_right = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [23:0] got_l [64];
    logic [23:0] got_r [64];
    int ngot = 0;

    always #10 clk = ~clk;

    audio_fifo_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .irq(irq),
        .play_valid(play_valid), .play_ready(play_ready),
        .play_left(play_left), .play_right(play_right),
        .cap_valid(cap_valid), .cap_ready(cap_ready),
        .cap_left(cap_left), .cap_right(cap_right)
    );

    // Drain monitor for the playback port
    always @(posedge clk) begin
        if (rst_n && play_valid && play_ready && ngot < 64) begin
            got_l[ngot] = play_left;
            got_r[ngot] = play_right;
            ngot = ngot + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        awvalid = 1'b0; wvalid = 1'b0;
        chk(bvalid && bresp == 2'b00, "R10", {bvalid, bresp}, 3'b100);
        @(posedge clk); #1;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        arvalid = 1'b0;
        chk(rvalid && rresp == 2'b00, "R10", {rvalid, rresp}, 3'b100);
        d = rdata;
        @(posedge clk); #1;
    endtask

    task automatic cap_offer(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        cap_left = l; cap_right = r; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(play_valid == 1'b0 && cap_ready == 1'b1, "R1", {play_valid, cap_ready}, 2'b01);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_000C, "R1", rd, 32'hC);
        chk(irq == 1'b0, "R9", irq, 0);

        // R4 vector table: push, then drain and compare widened halves
        for (int i = 0; i < NVEC; i++) bus_write(6'h04, VEC[i]);
        chk(play_valid == 1'b1, "R4", play_valid, 1);
        base = ngot;
        @(negedge clk); play_ready = 1'b1;
        repeat (NVEC + 2) @(negedge clk);
        play_ready = 1'b0;
        chk(ngot - base == NVEC, "R4", ngot - base, NVEC);
        for (int i = 0; i < NVEC; i++) begin
            chk(got_r[base+i] == {VEC[i][31:16], 8'h00} && got_l[base+i] == {VEC[i][15:0], 8'h00},
                "R4", {got_r[base+i], got_l[base+i]}, {VEC[i][31:16], 8'h00, VEC[i][15:0], 8'h00});
        end

        // R5 vector table: capture with nonzero low bytes, read back narrowed
        for (int i = 0; i < NVEC; i++) cap_offer({VEC[i][15:0], 8'hA5}, {VEC[i][31:16], 8'h3C});
        for (int i = 0; i < NVEC; i++) begin
            bus_read(6'h08, rd);
            chk(rd == VEC[i], "R5", rd, VEC[i]);
        end

        // R7 empty pop returns zero, FIFO stays empty
        bus_read(6'h08, rd);
        chk(rd == 32'd0, "R7", rd, 0);
        bus_read(6'h00, rd);
        chk(rd[2] == 1'b1, "R7", rd, 32'hC);

        // R6 playback full: DEPTH+1 pushes, last dropped
        for (int i = 0; i <= DEPTH; i++) bus_write(6'h04, 32'h0100_0000 + i);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_0024, "R3", rd, 32'h24);
        base = ngot;
        @(negedge clk); play_ready = 1'b1;
        repeat (DEPTH + 3) @(negedge clk);
        play_ready = 1'b0;
        chk(ngot - base == DEPTH, "R6", ngot - base, DEPTH);
        chk(got_l[ngot-1] == {16'(DEPTH - 1), 8'h00}, "R6", got_l[ngot-1], {16'(DEPTH - 1), 8'h00});

        // R6 capture full: DEPTH+1 offers, ready drops, last discarded
        for (int i = 0; i <= DEPTH; i++) cap_offer({16'(i), 8'h00}, 24'h777700);
        #1;
        chk(cap_ready == 1'b0, "R5", cap_ready, 0);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_0018, "R3", rd, 32'h18);
        for (int i = 0; i < DEPTH; i++) bus_read(6'h08, rd);
        chk(rd == {16'h7777, 16'(DEPTH - 1)}, "R6", rd, {16'h7777, 16'(DEPTH - 1)});
        bus_read(6'h08, rd);
        chk(rd == 32'd0, "R6", rd, 0);

        // R2 clear commands, bits not stored
        bus_write(6'h04, 32'h1111_2222);
        cap_offer(24'h123456, 24'h654321);
        bus_write(6'h00, 32'h1);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_0008, "R2", rd, 32'h8);
        bus_write(6'h00, 32'h2);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_000C, "R2", rd, 32'hC);

        // R8 unused offsets
        cap_offer(24'hABCD00, 24'h123400);
        bus_write(6'h0C, 32'hFFFF_FFFF);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        bus_write(6'h20, 32'h0000_0003);
        bus_read(6'h0C, rd);
        chk(rd == 32'd0, "R8", rd, 0);
        bus_read(6'h30, rd);
        chk(rd == 32'd0, "R8", rd, 0);
        bus_read(6'h00, rd);
        chk(rd == 32'h0000_0008, "R8", rd, 32'h8);
        bus_read(6'h08, rd);
        chk(rd == 32'h1234_ABCD, "R8", rd, 32'h1234_ABCD);

        // R10 write priority: write and read presented together
        @(negedge clk);
        awaddr = 6'h04; wdata = 32'hCAFE_BEEF; awvalid = 1'b1; wvalid = 1'b1;
        araddr = 6'h00; arvalid = 1'b1;
        #1;
        chk(awready == 1'b1 && arready == 1'b0, "R10", {awready, arready}, 2'b10);
        @(posedge clk); #1;
        awvalid = 1'b0; wvalid = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        arvalid = 1'b0;
        chk(rvalid && rdata == 32'h0000_0004, "R10", rdata, 32'h4);
        @(posedge clk); #1;
        bus_write(6'h00, 32'h1);

        // R11 playback: push B in the same cycle as draining A
        bus_write(6'h04, 32'hAAAA_0001);
        base = ngot;
        fork
            bus_write(6'h04, 32'hBBBB_0002);
            begin @(negedge clk); play_ready = 1'b1; end
        join
        repeat (3) @(negedge clk);
        play_ready = 1'b0;
        chk(ngot - base == 2, "R11", ngot - base, 2);
        chk(got_r[base] == 24'hAAAA00 && got_r[base+1] == 24'hBBBB00, "R11",
            {got_r[base], got_r[base+1]}, {24'hAAAA00, 24'hBBBB00});
        chk(play_valid == 1'b0, "R11", play_valid, 0);

        // R11 capture: pop A in the same cycle as storing B
        cap_offer(24'h000100, 24'h000200);
        fork
            bus_read(6'h08, rd);
            begin
                @(negedge clk);
                cap_left = 24'h0003FF; cap_right = 24'h0004FF; cap_valid = 1'b1;
                @(posedge clk); #1;
                cap_valid = 1'b0;
            end
        join
        chk(rd == 32'h0002_0001, "R11", rd, 32'h0002_0001);
        bus_read(6'h08, rd);
        chk(rd == 32'h0004_0003, "R11", rd, 32'h0004_0003);
        chk(irq == 1'b0, "R9", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule